// File: doc/BRIEF.md
# Not-Recently-Used Replacement Selector

This block holds the replacement state of a set-associative cache. Each way of each set has one usage flag. A hit or a fill on a way clears that way's flag. When the flags of a set would all be zero, the whole set is refilled with ones. When the cache needs to evict a line, the block picks the lowest-numbered way whose flag is still one. Tag storage, data storage and hit detection sit outside the block, which receives way numbers that are already resolved.

The cache controller drives a touch port with a set index and a way for every hit or fill. It drives a victim-request port with a set index and reads back the chosen way one cycle later. Both ports may be active in the same cycle, for the same set or for different sets.

Top module: `nru_selector`

## Requirements
- R1: After reset every flag of every set is one, so a victim request to any set returns way 0, and `vic_valid` is low until the first request.
- R2: A touch (`touch_valid` high) clears only the flag of `touch_way` in `touch_set`. The flags of every other set are unchanged.
- R3: If clearing the touched flag would leave the set with every flag at zero, all flags of that set become one in the same update, so no set ever holds all zeros.
- R4: The victim is the lowest-numbered way whose flag is one in the requested set.
- R5: `vic_valid` is high in exactly the cycle after `vic_req` is sampled high, with `vic_way` valid in that cycle. It is low otherwise.
- R6: When a touch and a victim request name the same set in one cycle, the victim is chosen from the flags as they were before that touch.
- R7: With `touch_valid` low, `touch_set` and `touch_way` have no effect on any flag.
- R8: Touching a way whose flag is already zero leaves the set unchanged, unless the refill of R3 applies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| touch_valid | input | 1 | A hit or fill on the named way |
| touch_set | input | $clog2(SETS) | Set index of the touch |
| touch_way | input | $clog2(WAYS) | Way that was used |
| vic_req | input | 1 | Request for an eviction choice |
| vic_set | input | $clog2(SETS) | Set index of the request |
| vic_valid | output | 1 | Victim result valid, one cycle after the request |
| vic_way | output | $clog2(WAYS) | Chosen way to evict |

## Verification
The bench uses a configuration of four sets and four ways and keeps its own model of the flags. Directed sequences come first:
- a touch followed by a request to a different set, which tells set isolation apart from a shared vector;
- touching every way in turn, which shows the all-zero refill happening in the same update and not a cycle late;
- a same-set touch and request in one cycle, which separates pre-update selection from post-update selection;
- a touch to an already-cleared way, which must leave the flags as they were;
- a touch with `touch_valid` held low, which must have no effect.

A long arithmetic sweep then crosses sets and ways with and without concurrent touches, so that many different flag patterns reach the lowest-way priority choice.

// File: rtl/nru_selector.sv
module nru_selector #(
  parameter int SETS = 64,
  parameter int WAYS = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    touch_valid,
  input  logic [$clog2(SETS)-1:0] touch_set,
  input  logic [$clog2(WAYS)-1:0] touch_way,
  input  logic                    vic_req,
  input  logic [$clog2(SETS)-1:0] vic_set,
  output logic                    vic_valid,
  output logic [$clog2(WAYS)-1:0] vic_way
);
  localparam int WW = $clog2(WAYS);

  logic [WAYS-1:0]      nru_q [SETS];
  logic [WAYS-1:0]      touch_row, touch_clr, touch_nxt, vic_row;
  logic [WW-1:0]        vic_pick;
  logic [SETS*WAYS-1:0] state_flat;

  assign touch_row = nru_q[touch_set];
  assign touch_clr = touch_row & ~(WAYS'(1) << touch_way);
  assign touch_nxt = (touch_clr == '0) ? '1 : touch_clr;
  assign vic_row   = nru_q[vic_set];

  always_comb begin
    vic_pick = '0;
    for (int w = WAYS - 1; w >= 0; w--)
      if (vic_row[w]) vic_pick = WW'(w);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) nru_q[s] <= '1;
      vic_valid <= 1'b0;
      vic_way   <= '0;
    end else begin
      if (touch_valid) nru_q[touch_set] <= touch_nxt;
      vic_valid <= vic_req;
      if (vic_req) vic_way <= vic_pick;
    end
  end

  for (genvar s = 0; s < SETS; s++) begin : g_flat
    assign state_flat[s*WAYS +: WAYS] = nru_q[s];
  end
endmodule

// File: rtl/nru_selector_chk.sv
module nru_selector_chk #(
  parameter int SETS = 64,
  parameter int WAYS = 8
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    touch_valid,
  input logic [$clog2(SETS)-1:0] touch_set,
  input logic [$clog2(WAYS)-1:0] touch_way,
  input logic                    vic_req,
  input logic [$clog2(SETS)-1:0] vic_set,
  input logic                    vic_valid,
  input logic [$clog2(WAYS)-1:0] vic_way,
  input logic [SETS*WAYS-1:0]    state_flat
);
  logic [WAYS-1:0] req_row_q, tch_row_now;
  logic [$clog2(SETS)-1:0] tch_set_q;
  logic [$clog2(WAYS)-1:0] tch_way_q;

  always_ff @(posedge clk) begin
    if (vic_req) req_row_q <= state_flat[vic_set*WAYS +: WAYS];
    tch_set_q <= touch_set;
    tch_way_q <= touch_way;
  end
  assign tch_row_now = state_flat[tch_set_q*WAYS +: WAYS];

  for (genvar s = 0; s < SETS; s++) begin : g_set
    // R3
    never_all_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      state_flat[s*WAYS +: WAYS] != '0);
  end

  // R5
  vic_valid_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vic_req |=> vic_valid);

  // R5
  vic_valid_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !vic_req |=> !vic_valid);

  // R4
  vic_lowest_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vic_req |=> (req_row_q[vic_way] &&
                 ((req_row_q & ((WAYS'(1) << vic_way) - WAYS'(1))) == '0)));

  // R2
  touch_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    touch_valid |=> (!tch_row_now[tch_way_q] || (&tch_row_now)));

  // R7
  idle_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !touch_valid |=> $stable(state_flat));
endmodule

bind nru_selector nru_selector_chk #(.SETS(SETS), .WAYS(WAYS)) u_chk (
  .clk(clk), .rst_n(rst_n), .touch_valid(touch_valid), .touch_set(touch_set),
  .touch_way(touch_way), .vic_req(vic_req), .vic_set(vic_set),
  .vic_valid(vic_valid), .vic_way(vic_way), .state_flat(state_flat)
);

// File: tb/nru_selector_tb.sv
module nru_selector_tb;
  localparam int SETS = 4;
  localparam int WAYS = 4;

  logic       clk = 0, rst_n = 0;
  logic       touch_valid = 0, vic_req = 0;
  logic [1:0] touch_set = 0, touch_way = 0, vic_set = 0;
  logic       vic_valid;
  logic [1:0] vic_way;

  int compared = 0, mismatched = 0;
  bit done = 0;
  logic [WAYS-1:0] model [SETS];

  nru_selector #(.SETS(SETS), .WAYS(WAYS)) u_dut (
    .clk(clk), .rst_n(rst_n), .touch_valid(touch_valid), .touch_set(touch_set),
    .touch_way(touch_way), .vic_req(vic_req), .vic_set(vic_set),
    .vic_valid(vic_valid), .vic_way(vic_way)
  );

  always #5 clk = ~clk;

  function automatic int lowest(input logic [WAYS-1:0] v);
    for (int w = 0; w < WAYS; w++) if (v[w]) return w;
    return 0;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc(input bit tv, input int ts, input int tw,
                     input bit rv, input int rs, input string req);
    int exp_w;
    logic [WAYS-1:0] nxt;
    @(negedge clk);
    touch_valid = tv; touch_set = 2'(ts); touch_way = 2'(tw);
    vic_req = rv; vic_set = 2'(rs);
    exp_w = lowest(model[rs]);
    if (tv) begin
      nxt = model[ts] & ~(WAYS'(1) << tw);
      model[ts] = (nxt == '0) ? '1 : nxt;
    end
    @(posedge clk); #1;
    touch_valid = 0; vic_req = 0;
    if (rv) begin
      check(req, int'(vic_valid), 1);
      check(req, int'(vic_way), exp_w);
    end
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    for (int s = 0; s < SETS; s++) model[s] = '1;
    repeat (3) @(posedge clk);
    #1;
    // R1: no valid before any request
    check("R1", int'(vic_valid), 0);
    @(negedge clk); rst_n = 1;
    // R1: every set starts with victim 0
    for (int s = 0; s < SETS; s++) cyc(0, 0, 0, 1, s, "R1");
    // R5: valid drops when no request
    cyc(0, 0, 0, 0, 0, "R5");
    check("R5", int'(vic_valid), 0);
    // R2: touch set0 way0, isolation from set1
    cyc(1, 0, 0, 0, 0, "R2");
    cyc(0, 0, 0, 1, 0, "R2");
    cyc(0, 0, 0, 1, 1, "R2");
    // R3: clearing the last flag refills the set
    cyc(1, 0, 1, 0, 0, "R3");
    cyc(1, 0, 2, 1, 0, "R3");
    cyc(1, 0, 3, 1, 0, "R3");
    check("R3", int'(model[0]), 15);
    cyc(0, 0, 0, 1, 0, "R3");
    // R7: touch inputs ignored without touch_valid
    cyc(0, 2, 0, 0, 0, "R7");
    cyc(0, 0, 0, 1, 2, "R7");
    // R6: same-set touch and request see pre-update flags
    cyc(1, 1, 0, 1, 1, "R6");
    cyc(0, 0, 0, 1, 1, "R6");
    // R8: touching a cleared way changes nothing
    cyc(1, 1, 0, 0, 0, "R8");
    cyc(0, 0, 0, 1, 1, "R8");
    cyc(1, 1, 2, 0, 0, "R8");
    cyc(1, 1, 2, 1, 1, "R8");
    cyc(0, 0, 0, 1, 1, "R8");
    // R4: arithmetic sweep over sets, ways and concurrent touches
    for (int i = 0; i < 600; i++)
      cyc(i % 5 != 0, i % SETS, (i * 7 + i / 4) % WAYS,
          i % 7 != 3, (i * 3 + i / 9) % SETS, "R4");
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule